// File: doc/BRIEF.md
# Differential Gray Pixel Decoder

This block sits at the receiving end of a pixel link whose sender may apply two kinds of coding to each 12-bit sample so that fewer output bits toggle between neighbouring pixels. The sender can Gray-code each word, and it can replace each sample with its difference from an earlier pixel of the same line. The decoder undoes both steps in a fixed order. It first converts the Gray-coded word back to binary, over either the full 12 bits or a 10-bit upper field. It then rebuilds absolute pixel values by adding each decoded difference, modulo 4096, to the value it rebuilt one or two pixels earlier.

Each line starts with a line-start pulse. At a programmable position after that pulse the sender transmits one or two reference pixels as absolute values. The decoder loads these into a short history of rebuilt values. Every later pixel of the line is reconstructed from that history. The decoded sample leaves through one register, together with a flag that marks it as meaningful.

Top module: `diff_gray_decoder`

## Requirements
- R1: While reset is held, and after reset until the first line-start pulse, `pixValid` is 0. `pixOut` resets to 0.
- R2: The cycle in which `lineStart` is high carries pixel 1 of a line. The reference position is K = 3 + `refSel` (`refSel` 0..3 gives pixel 3..6). In differential mode, reference pixels come out as the converted word with no addition.
- R3: With `grayEn` = 0, the converted word equals `codeIn`.
- R4: With `grayEn` = 1 and `width10` = 0, all 12 bits are Gray-decoded. Each binary bit is the XOR of all code bits from bit 11 down to that bit.
- R5: With `grayEn` = 1 and `width10` = 1, bits 11:2 are Gray-decoded as one 10-bit field, and bits 1:0 pass unchanged.
- R6: With `diffEn` = 0, every pixel from pixel 1 onward comes out as the converted word, with `pixValid` = 1.
- R7: With `diffEn` = 1, pixels before position K come out with `pixValid` = 0.
- R8: With `diffEn` = 1 and `oneRef` = 0, pixels K and K+1 are references. Every later pixel n gives converted word plus output of pixel n-2, modulo 4096.
- R9: With `diffEn` = 1 and `oneRef` = 1, only pixel K is a reference. Every later pixel n gives converted word plus output of pixel n-1, modulo 4096.
- R10: The result for a pixel presented at one clock edge appears on `pixOut`/`pixValid` after that edge. The latency is exactly one cycle.
- R11: A line-start pulse in the middle of a line restarts the pixel count at 1, so the reference search begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | High during pixel 1 of each line |
| codeIn | input | 12 | Coded pixel word |
| refSel | input | 2 | Reference position select, K = 3 + refSel |
| grayEn | input | 1 | Gray decoding enable |
| diffEn | input | 1 | Differential reconstruction enable |
| width10 | input | 1 | Gray field width: 0 = 12 bits, 1 = upper 10 bits |
| oneRef | input | 1 | 1 = single reference pixel, 0 = two reference pixels |
| pixOut | output | 12 | Reconstructed pixel |
| pixValid | output | 1 | pixOut holds a meaningful sample |

## Verification
The bench sweeps all 64 combinations of reference position, Gray enable, differential enable, field width and reference count. Each combination gets a full line produced by an arithmetic model of the sender. Lines are random walks of small steps that start anywhere in the code range, so reconstruction regularly wraps across 0/4095. This separates a correct modulo adder from a saturating one, and a one-pixel look-back from a two-pixel look-back. Sweeping the reference position catches off-by-one errors in the count from the line-start pulse. Lines follow one another with no gap, so each new line-start pulse must drop the valid flag again in differential mode.

// File: rtl/dgd_pkg.sv
package dgd_pkg;
  typedef struct packed {
    logic isRef;      // pass converted word, load history
    logic useSum;     // add history value
    logic validNext;  // output valid after this edge
  } pixStrobe_t;
endpackage

// File: rtl/dgd_gray2bin.sv
module dgd_gray2bin #(
  parameter int W = 12
) (
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  assign binOut[W-1] = grayIn[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : gXorChain
    assign binOut[i] = binOut[i+1] ^ grayIn[i];
  end

  // Re-encoding the result must give back the input
  always_comb begin
    if (!$isunknown(grayIn))
      AST_GRAY_INVERSE: assert ((binOut ^ (binOut >> 1)) == grayIn); // R4
  end
endmodule

// File: rtl/dgd_ctrl.sv
module dgd_ctrl
  import dgd_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int REF_BASE = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  logic [1:0] refSel,
  input  logic       diffEn,
  input  logic       oneRef,
  output pixStrobe_t strb
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             seenLine;
  logic             inLine;
  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] refPos;
  logic [IDX_W-1:0] lastRef;

  always_comb begin
    if (lineStart)
      curIdx = IDX_W'(1);
    else if (idxReg == IDX_MAX)
      curIdx = IDX_MAX;
    else
      curIdx = idxReg + 1'b1;
    refPos  = IDX_W'(REF_BASE) + IDX_W'(refSel);
    lastRef = oneRef ? refPos : refPos + 1'b1;
    inLine  = lineStart | seenLine;
    strb.isRef     = inLine & diffEn & (curIdx >= refPos) & (curIdx <= lastRef);
    strb.useSum    = inLine & diffEn & (curIdx > lastRef);
    strb.validNext = inLine & (~diffEn | (curIdx >= refPos));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenLine <= 1'b0;
      idxReg   <= '0;
    end else begin
      seenLine <= seenLine | lineStart;
      idxReg   <= curIdx;
    end
  end

  AST_IDX_MONOTONE: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> idxReg >= $past(idxReg)); // R11

  AST_ONE_REF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.isRef && oneRef) |=>
      (!strb.isRef || !$stable(refSel) || !$stable(oneRef))); // R9

  AST_TWO_REF_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(strb.isRef) && !oneRef) |=>
      (strb.isRef || lineStart || !$stable({refSel, oneRef, diffEn}))); // R8

  AST_NO_REF_BEFORE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !inLine |-> !strb.validNext && !strb.useSum); // R1
endmodule

// File: rtl/dgd_datapath.sv
module dgd_datapath
  import dgd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NARROW_W = 10,
  parameter int HIST_D   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] codeIn,
  input  logic              grayEn,
  input  logic              width10,
  input  logic              oneRef,
  input  pixStrobe_t        strb,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid
);
  localparam int RAW_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   fullBin;
  logic [NARROW_W-1:0] narrowBin;
  logic [DATA_W-1:0]   conv;
  logic [DATA_W-1:0]   lookBack;
  logic [DATA_W-1:0]   recon;
  logic [DATA_W-1:0]   hist [HIST_D];

  dgd_gray2bin #(.W(DATA_W)) uFull (
    .grayIn (codeIn),
    .binOut (fullBin)
  );

  dgd_gray2bin #(.W(NARROW_W)) uNarrow (
    .grayIn (codeIn[DATA_W-1 -: NARROW_W]),
    .binOut (narrowBin)
  );

  always_comb begin
    if (!grayEn)
      conv = codeIn;
    else if (width10)
      conv = {narrowBin, codeIn[RAW_W-1:0]};
    else
      conv = fullBin;
    lookBack = oneRef ? hist[0] : hist[HIST_D-1];
    recon    = strb.useSum ? conv + lookBack : conv;  // wraps modulo 2^DATA_W
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixOut   <= recon;
      pixValid <= strb.validNext;
    end
  end

  for (genvar i = 0; i < HIST_D; i++) begin : gHist
    always_ff @(posedge clk) begin
      if (!rstN)
        hist[i] <= '0;
      else if (i == 0)
        hist[i] <= recon;
      else
        hist[i] <= hist[i-1];
    end
  end

  AST_REF_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (strb.isRef && !grayEn) |=> pixOut == $past(codeIn)); // R2

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strb.validNext |=> pixValid); // R10

  AST_REF_SUM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.isRef && strb.useSum)); // R8
endmodule

// File: rtl/diff_gray_decoder.sv
module diff_gray_decoder
  import dgd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NARROW_W = 10,
  parameter int IDX_W    = 4,
  parameter int REF_BASE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [DATA_W-1:0] codeIn,
  input  logic [1:0]        refSel,
  input  logic              grayEn,
  input  logic              diffEn,
  input  logic              width10,
  input  logic              oneRef,
  output logic [DATA_W-1:0] pixOut,
  output logic              pixValid
);
  pixStrobe_t strb;

  dgd_ctrl #(.IDX_W(IDX_W), .REF_BASE(REF_BASE)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .refSel    (refSel),
    .diffEn    (diffEn),
    .oneRef    (oneRef),
    .strb      (strb)
  );

  dgd_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .HIST_D(2)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .codeIn   (codeIn),
    .grayEn   (grayEn),
    .width10  (width10),
    .oneRef   (oneRef),
    .strb     (strb),
    .pixOut   (pixOut),
    .pixValid (pixValid)
  );
endmodule

// File: tb/sim_diff_gray_decoder.sv
module sim_diff_gray_decoder;
  localparam int LINE = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic [11:0] codeIn = '0;
  logic [1:0]  refSel = '0;
  logic        grayEn = 1'b0;
  logic        diffEn = 1'b0;
  logic        width10 = 1'b0;
  logic        oneRef = 1'b0;
  logic [11:0] pixOut;
  logic        pixValid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  bit          pend = 0;
  bit          pendValid;
  logic [11:0] pendVal;
  string       pendValTag;
  string       pendVldTag;

  always #2.5 clk = ~clk;

  diff_gray_decoder u0 (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .codeIn(codeIn),
    .refSel(refSel), .grayEn(grayEn), .diffEn(diffEn), .width10(width10),
    .oneRef(oneRef), .pixOut(pixOut), .pixValid(pixValid)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] enc(input logic [11:0] x, input bit g, input bit w10);
    if (!g) return x;
    if (w10) return {x[11:2] ^ (x[11:2] >> 1), x[1:0]};
    return x ^ (x >> 1);
  endfunction

  task automatic checkPending();
    if (pend) begin
      check(pendVldTag, {11'd0, pixValid}, {11'd0, pendValid});
      if (pendValid) check(pendValTag, pixOut, pendVal);
    end
  endtask

  task automatic runLine(input int cfg);
    logic [11:0] p [LINE];
    bit g, df, w, o;
    int k, d, lastRef;
    g = cfg[2]; df = cfg[3]; w = cfg[4]; o = cfg[5];
    k = 3 + cfg[1:0];
    d = o ? 1 : 2;
    lastRef = k + d - 1;
    p[0] = 12'($urandom);
    for (int i = 1; i < LINE; i++) p[i] = p[i-1] + 12'($urandom_range(0, 64) - 32);
    for (int n = 1; n <= LINE; n++) begin
      logic [11:0] word;
      if (!df) word = enc(p[n-1], g, w);
      else if (n < k) word = enc(12'($urandom), g, w);
      else if (n <= lastRef) word = enc(p[n-1], g, w);
      else word = enc(p[n-1] - p[n-1-d], g, w);
      @(negedge clk);
      checkPending();
      lineStart = (n == 1);
      codeIn = word;
      refSel = cfg[1:0]; grayEn = g; diffEn = df; width10 = w; oneRef = o;
      pend = 1;
      pendValid = !df || (n >= k);
      pendVal = p[n-1];
      if (!df) begin
        pendVldTag = (n == 1) ? "R10" : "R6";
        pendValTag = !g ? "R3" : (w ? "R5" : "R4");
      end else begin
        pendVldTag = (n == 1) ? "R11" : "R7";
        pendValTag = (n <= lastRef) ? "R2" : (o ? "R9" : "R8");
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pixOut, 12'd0);
    check("R1", {11'd0, pixValid}, 12'd0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      diffEn = i[0];
      codeIn = 12'(i * 777);
      @(negedge clk);
      check("R1", {11'd0, pixValid}, 12'd0);
    end
    for (int rep = 0; rep < 2; rep++)
      for (int cfg = 0; cfg < 64; cfg++) runLine(cfg);
    @(negedge clk);
    checkPending();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule